// File: doc/BRIEF.md
# Real-Time Clock Seconds Update and Alarm Engine

This block keeps the time of day (seconds, minutes, hours) for a PC-style real-time clock. It advances the time once per second. Each second it opens an update window of fixed length, driven by a microsecond tick, and while the window is open it shows an update-in-progress bit. When the window closes it publishes the new time to the registers that software can see. The same closing also produces the set-pulses for the interrupt flag register, for update-ended and for alarm.

The visible registers follow the format chosen by the control register. They can hold packed two-digit decimal (BCD) or plain binary values. The hour can be shown in 24-hour form or in 12-hour form, where bit 7 of the hour register marks PM. The control inputs can stop the clock through the oscillator divider control, or freeze the visible copy for software through the set bit. The host can load a new time of day in the current format.

Date keeping is left to a neighbouring block. This block gives it a one-cycle carry pulse each time the hours wrap to midnight.

Top module: `rtc_tick_engine`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `uip` reads 0, `flag_set` reads 0x00, `day_carry` reads 0, and the visible time is midnight (00:00:00) encoded in the current format.
- R2: When `chain_ctl` is 2'b11 (divider chain held in reset), a `sec_tick` is ignored: `uip` stays 0 and the time does not advance.
- R3: An accepted `sec_tick` sets `uip` at the next clock edge and advances the internal time by one second. `uip` stays 1 until the edge at which the UIP_US-th `us_tick` after the tick is sampled. At that same edge `uip` clears and the visible time registers take the new time.
- R4: A `sec_tick` that arrives while `uip` is 1 is ignored and does not advance the time.
- R5: While `set_mode` is 1, a `sec_tick` opens no update window and leaves the visible time unchanged. The internal time still advances, so the first update after `set_mode` returns to 0 shows every second counted.
- R6: At the edge that closes the window, if `upd_ie` is 1, `flag_set` carries mask 0x90 for exactly one cycle.
- R7: At the edge that closes the window, if `alm_ie` is 1 and every alarm field matches the new visible time byte for byte, `flag_set` carries mask 0xA0 for one cycle. A mismatch in any field gives no alarm bits.
- R8: An alarm field whose bits 7:6 are both 1 is a don't-care and matches any value.
- R9: When `bin_mode` is 0, each time value is stored as BCD with the tens digit in bits 7:4 and the units digit in bits 3:0. When `bin_mode` is 1, the plain binary value is stored.
- R10: When `hr24` is 0, the hour register holds 1 to 12 with bit 7 set for PM. Hour 0 reads as 12 with bit 7 clear. Hour 12 reads as 12 with bit 7 set. Hours 13 to 23 read as 1 to 11 with bit 7 set.
- R11: Seconds and minutes wrap from 59 to 0 and hours from 23 to 0. The wrap of the hours raises `day_carry` for exactly one cycle, one edge after the tick.
- R12: A cycle with `ld_en` high loads `ld_sec`, `ld_min` and `ld_hour`, read in the current format. They are visible re-encoded after the next edge.
- R13: A change of `bin_mode` or `hr24` re-encodes the visible time in the new format at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_tick | input | 1 | One-cycle pulse, once per second |
| us_tick | input | 1 | One-cycle pulse, once per microsecond |
| chain_ctl | input | 2 | Divider control bits 6:5 of control register A; 2'b11 stops the clock |
| set_mode | input | 1 | Control B bit 7: freeze the visible time |
| upd_ie | input | 1 | Control B bit 4: update-ended flag enable |
| alm_ie | input | 1 | Control B bit 5: alarm flag enable |
| hr24 | input | 1 | Control B bit 1: 1 = 24-hour format |
| bin_mode | input | 1 | Control B bit 2: 1 = binary, 0 = BCD |
| alm_sec | input | 8 | Seconds alarm |
| alm_min | input | 8 | Minutes alarm |
| alm_hour | input | 8 | Hours alarm |
| ld_en | input | 1 | Load the time-of-day values below |
| ld_sec | input | 8 | Seconds to load, current format |
| ld_min | input | 8 | Minutes to load, current format |
| ld_hour | input | 8 | Hours to load, current format |
| time_sec | output | 8 | Visible seconds register |
| time_min | output | 8 | Visible minutes register |
| time_hour | output | 8 | Visible hours register |
| uip | output | 1 | Update-in-progress bit |
| flag_set | output | 8 | One-cycle set mask for the interrupt flag register |
| day_carry | output | 1 | One-cycle pulse when the hours wrap to 0 |

## Verification
The results arrive at different times, and the bench samples each one at the point where it is due. `uip` and `day_carry` show up one edge after the tick. The new visible time and the `flag_set` mask show up at the edge of the 244th microsecond tick after that, and the mask has dropped again one edge later. Loads and format changes show up after a single edge.

The bench holds `us_tick` high on every cycle, so the closing edge comes 244 clocks after the tick edge. Every scenario therefore checks `uip` just before that edge and checks the time and the flags right after it. Ignored ticks (inside the window, halted clock, set mode) are checked through `uip` and through the time shown by the next real update.

// File: rtl/rtc_upd_pkg.sv
package rtc_upd_pkg;

    localparam int REG_W  = 8;
    localparam int SEC_W  = 6;
    localparam int MIN_W  = 6;
    localparam int HR_W   = 5;
    localparam int VAL_W  = 7;
    localparam int N_FLD  = 3;

    localparam logic [REG_W-1:0] FLG_UPDATE = 8'h90;
    localparam logic [REG_W-1:0] FLG_ALARM  = 8'hA0;
    localparam logic [1:0]       ALM_ANY    = 2'b11;
    localparam logic [1:0]       CHAIN_HOLD = 2'b11;

    typedef struct packed {
        logic [HR_W-1:0]  hr;
        logic [MIN_W-1:0] min;
        logic [SEC_W-1:0] sec;
    } tod_t;

    typedef struct packed {
        logic [REG_W-1:0] hr;
        logic [REG_W-1:0] min;
        logic [REG_W-1:0] sec;
    } tod_reg_t;

    typedef struct packed {
        logic bin;
        logic h24;
    } fmt_t;

    typedef enum logic {
        WIN_IDLE = 1'b0,
        WIN_OPEN = 1'b1
    } win_state_t;

    // value 0..99 to register byte
    function automatic logic [REG_W-1:0] enc_val(input logic [VAL_W-1:0] v,
                                                 input logic bin);
        logic [3:0] tens;
        logic [3:0] ones;
        tens = 4'(v / 7'd10);
        ones = 4'(v % 7'd10);
        return bin ? {1'b0, v} : {tens, ones};
    endfunction

    function automatic logic [VAL_W-1:0] dec_val(input logic [REG_W-1:0] r,
                                                 input logic bin);
        return bin ? r[VAL_W-1:0]
                   : VAL_W'(7'(r[7:4]) * 7'd10 + 7'(r[3:0]));
    endfunction

    function automatic logic [REG_W-1:0] enc_hour(input logic [HR_W-1:0] h,
                                                  input fmt_t f);
        logic [HR_W-1:0] h12;
        logic            pm;
        if (f.h24) begin
            return enc_val({2'b00, h}, f.bin);
        end
        pm  = (h >= 5'd12);
        h12 = pm ? h - 5'd12 : h;
        if (h12 == '0) h12 = 5'd12;
        return {pm, 7'b0} | enc_val({2'b00, h12}, f.bin);
    endfunction

    function automatic logic [HR_W-1:0] dec_hour(input logic [REG_W-1:0] r,
                                                 input fmt_t f);
        logic [VAL_W-1:0] v;
        logic [HR_W-1:0]  base;
        if (f.h24) begin
            return HR_W'(dec_val(r, f.bin));
        end
        v    = dec_val({1'b0, r[6:0]}, f.bin);
        base = (v == 7'd12) ? '0 : HR_W'(v);
        return r[7] ? base + 5'd12 : base;
    endfunction

    function automatic tod_reg_t enc_tod(input tod_t t, input fmt_t f);
        tod_reg_t o;
        o.sec = enc_val({1'b0, t.sec}, f.bin);
        o.min = enc_val({1'b0, t.min}, f.bin);
        o.hr  = enc_hour(t.hr, f);
        return o;
    endfunction

endpackage

// File: rtl/rtc_tod_counter.sv
module rtc_tod_counter
    import rtc_upd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic adv,
    input  logic ld_en,
    input  tod_t ld_tod,
    output tod_t tod,
    output logic carry
);
    localparam logic [SEC_W-1:0] SEC_LAST = SEC_W'(59);
    localparam logic [MIN_W-1:0] MIN_LAST = MIN_W'(59);
    localparam logic [HR_W-1:0]  HR_LAST  = HR_W'(23);

    logic sec_wrap;
    logic min_wrap;
    logic hr_wrap;

    assign sec_wrap = adv && (tod.sec == SEC_LAST);
    assign min_wrap = sec_wrap && (tod.min == MIN_LAST);
    assign hr_wrap  = min_wrap && (tod.hr == HR_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            tod   <= '0;
            carry <= 1'b0;
        end else begin
            carry <= hr_wrap && !ld_en;
            if (ld_en) begin
                tod <= ld_tod;
            end else if (adv) begin
                tod.sec <= sec_wrap ? '0 : tod.sec + 1'b1;
                if (sec_wrap) tod.min <= min_wrap ? '0 : tod.min + 1'b1;
                if (min_wrap) tod.hr  <= hr_wrap ? '0 : tod.hr + 1'b1;
            end
        end
    end

    AST_SEC_RANGE: assert property (@(posedge clk) disable iff (rst)
        (tod.sec <= SEC_LAST) && (tod.min <= MIN_LAST) && (tod.hr <= HR_LAST)); // R11
    AST_SEC_WRAP: assert property (@(posedge clk) disable iff (rst)
        (adv && !ld_en && tod.sec == SEC_LAST) |=> (tod.sec == '0)); // R11

endmodule

// File: rtl/rtc_uip_window.sv
module rtc_uip_window
    import rtc_upd_pkg::*;
#(
    parameter int UIP_US = 244
) (
    input  logic clk,
    input  logic rst,
    input  logic sec_tick,
    input  logic us_tick,
    input  logic halt,
    input  logic set_mode,
    output logic adv,
    output logic uip,
    output logic done
);
    localparam int CNT_W = $clog2(UIP_US + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(UIP_US - 1);

    win_state_t       state;
    logic [CNT_W-1:0] cnt;
    logic             start;

    assign adv   = sec_tick && !halt && (state == WIN_IDLE);
    assign start = adv && !set_mode;
    assign done  = (state == WIN_OPEN) && us_tick && (cnt == CNT_LAST);
    assign uip   = (state == WIN_OPEN);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= WIN_IDLE;
            cnt   <= '0;
        end else begin
            case (state)
                WIN_IDLE: begin
                    cnt <= '0;
                    if (start) state <= WIN_OPEN;
                end
                WIN_OPEN: begin
                    if (done) begin
                        state <= WIN_IDLE;
                        cnt   <= '0;
                    end else if (us_tick) begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= WIN_IDLE;
            endcase
        end
    end

    AST_WINDOW_HOLD: assert property (@(posedge clk) disable iff (rst)
        (uip && !(us_tick && cnt == CNT_LAST)) |=> uip); // R3
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_LAST); // R3

endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
    import rtc_upd_pkg::*;
(
    input  tod_reg_t                     cur,
    input  logic [N_FLD-1:0][REG_W-1:0]  alm,
    output logic                         hit
);
    logic [N_FLD-1:0][REG_W-1:0] now;
    logic [N_FLD-1:0]            fld_ok;

    assign now = {cur.hr, cur.min, cur.sec};

    for (genvar i = 0; i < N_FLD; i++) begin : g_fld
        assign fld_ok[i] = (alm[i][7:6] == ALM_ANY) || (alm[i] == now[i]);
    end

    assign hit = &fld_ok;

endmodule

// File: rtl/rtc_tick_engine.sv
module rtc_tick_engine
    import rtc_upd_pkg::*;
#(
    parameter int UIP_US = 244
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sec_tick,
    input  logic       us_tick,
    input  logic [1:0] chain_ctl,
    input  logic       set_mode,
    input  logic       upd_ie,
    input  logic       alm_ie,
    input  logic       hr24,
    input  logic       bin_mode,
    input  logic [7:0] alm_sec,
    input  logic [7:0] alm_min,
    input  logic [7:0] alm_hour,
    input  logic       ld_en,
    input  logic [7:0] ld_sec,
    input  logic [7:0] ld_min,
    input  logic [7:0] ld_hour,
    output logic [7:0] time_sec,
    output logic [7:0] time_min,
    output logic [7:0] time_hour,
    output logic       uip,
    output logic [7:0] flag_set,
    output logic       day_carry
);
    fmt_t     cur_fmt;
    fmt_t     prev_fmt;
    tod_t     tod;
    tod_t     ld_tod;
    tod_reg_t fresh;
    tod_reg_t ld_vis;
    tod_reg_t vis;
    logic     halt;
    logic     adv;
    logic     done;
    logic     alm_hit;
    logic [VAL_W-1:0] ld_s_raw;
    logic [VAL_W-1:0] ld_m_raw;
    logic [HR_W-1:0]  ld_h_raw;

    assign cur_fmt = '{bin: bin_mode, h24: hr24};
    assign halt    = (chain_ctl == CHAIN_HOLD);

    // decode and sanitise host load in the current format
    always_comb begin
        ld_s_raw   = dec_val(ld_sec, bin_mode);
        ld_m_raw   = dec_val(ld_min, bin_mode);
        ld_h_raw   = dec_hour(ld_hour, cur_fmt);
        ld_tod.sec = (ld_s_raw < 7'd60) ? SEC_W'(ld_s_raw) : '0;
        ld_tod.min = (ld_m_raw < 7'd60) ? MIN_W'(ld_m_raw) : '0;
        ld_tod.hr  = (ld_h_raw < 5'd24) ? ld_h_raw : '0;
        ld_vis     = enc_tod(ld_tod, cur_fmt);
        fresh      = enc_tod(tod, cur_fmt);
    end

    rtc_uip_window #(.UIP_US(UIP_US)) u_win (
        .clk      (clk),
        .rst      (rst),
        .sec_tick (sec_tick),
        .us_tick  (us_tick),
        .halt     (halt),
        .set_mode (set_mode),
        .adv      (adv),
        .uip      (uip),
        .done     (done)
    );

    rtc_tod_counter u_cnt (
        .clk    (clk),
        .rst    (rst),
        .adv    (adv),
        .ld_en  (ld_en),
        .ld_tod (ld_tod),
        .tod    (tod),
        .carry  (day_carry)
    );

    rtc_alarm_match u_alm (
        .cur (fresh),
        .alm ({alm_hour, alm_min, alm_sec}),
        .hit (alm_hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vis      <= enc_tod('0, cur_fmt);
            prev_fmt <= cur_fmt;
            flag_set <= '0;
        end else begin
            prev_fmt <= cur_fmt;
            if (ld_en) begin
                vis <= ld_vis;
            end else if (done || (cur_fmt != prev_fmt)) begin
                vis <= fresh;
            end
            flag_set <= '0;
            if (done) begin
                flag_set <= (upd_ie ? FLG_UPDATE : 8'h00)
                          | ((alm_ie && alm_hit) ? FLG_ALARM : 8'h00);
            end
        end
    end

    assign time_sec  = vis.sec;
    assign time_min  = vis.min;
    assign time_hour = vis.hr;

    AST_HALT_NO_UIP: assert property (@(posedge clk) disable iff (rst)
        (halt && !uip) |=> !uip); // R2
    AST_SET_NO_UIP: assert property (@(posedge clk) disable iff (rst)
        (set_mode && !uip) |=> !uip); // R5
    AST_FLAG_AT_CLOSE: assert property (@(posedge clk) disable iff (rst)
        (flag_set != 8'h00) |-> $fell(uip)); // R6
    AST_CARRY_PULSE: assert property (@(posedge clk) disable iff (rst)
        day_carry |=> !day_carry); // R11
    AST_FLAG_MASK: assert property (@(posedge clk) disable iff (rst)
        (flag_set & 8'h4F) == 8'h00); // R7

endmodule

// File: tb/rtc_tick_engine_test.sv
module rtc_tick_engine_test;
    localparam int CLK_NS = 10;
    localparam int WIN    = 244;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sec_tick = 1'b0;
    logic       us_tick = 1'b1;
    logic [1:0] chain_ctl = 2'b01;
    logic       set_mode = 1'b0;
    logic       upd_ie = 1'b0;
    logic       alm_ie = 1'b0;
    logic       hr24 = 1'b1;
    logic       bin_mode = 1'b0;
    logic [7:0] alm_sec = 8'h00;
    logic [7:0] alm_min = 8'h00;
    logic [7:0] alm_hour = 8'h00;
    logic       ld_en = 1'b0;
    logic [7:0] ld_sec = 8'h00;
    logic [7:0] ld_min = 8'h00;
    logic [7:0] ld_hour = 8'h00;
    logic [7:0] time_sec;
    logic [7:0] time_min;
    logic [7:0] time_hour;
    logic       uip;
    logic [7:0] flag_set;
    logic       day_carry;

    int n_vec = 0;
    int n_bad = 0;
    logic finished = 1'b0;

    always #(CLK_NS/2) clk = ~clk;

    rtc_tick_engine uut (
        .clk(clk), .rst(rst), .sec_tick(sec_tick), .us_tick(us_tick),
        .chain_ctl(chain_ctl), .set_mode(set_mode), .upd_ie(upd_ie),
        .alm_ie(alm_ie), .hr24(hr24), .bin_mode(bin_mode),
        .alm_sec(alm_sec), .alm_min(alm_min), .alm_hour(alm_hour),
        .ld_en(ld_en), .ld_sec(ld_sec), .ld_min(ld_min), .ld_hour(ld_hour),
        .time_sec(time_sec), .time_min(time_min), .time_hour(time_hour),
        .uip(uip), .flag_set(flag_set), .day_carry(day_carry)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic chk_time(input string req, input logic [7:0] h, input logic [7:0] m,
                            input logic [7:0] s);
        chk(req, {8'h00, time_hour, time_min, time_sec}, {8'h00, h, m, s});
    endtask

    // one-cycle tick; returns just after the tick edge
    task automatic pulse_tick();
        @(negedge clk) sec_tick = 1'b1;
        @(negedge clk) sec_tick = 1'b0;
    endtask

    // waits from just after the tick edge to just after the closing edge
    task automatic finish_window(input string req);
        repeat (WIN - 1) @(negedge clk);
        chk(req, {31'b0, uip}, 32'd1);
        @(negedge clk);
        chk(req, {31'b0, uip}, 32'd0);
    endtask

    task automatic load(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s);
        @(negedge clk);
        ld_en = 1'b1; ld_hour = h; ld_min = m; ld_sec = s;
        @(negedge clk) ld_en = 1'b0;
    endtask

    task automatic t_reset();
        chk_time("R1 reset time", 8'h00, 8'h00, 8'h00);
        chk("R1 reset uip", {31'b0, uip}, 32'd0);
        chk("R1 reset flags", {24'b0, flag_set}, 32'd0);
        chk("R1 reset carry", {31'b0, day_carry}, 32'd0);
    endtask

    task automatic t_basic();
        load(8'h12, 8'h34, 8'h56);
        chk_time("R12 load bcd", 8'h12, 8'h34, 8'h56);
        pulse_tick();
        chk("R3 uip set after tick", {31'b0, uip}, 32'd1);
        chk_time("R3 old time in window", 8'h12, 8'h34, 8'h56);
        finish_window("R3 window length");
        chk_time("R9 bcd update", 8'h12, 8'h34, 8'h57);
        chk("R6 no update flag when disabled", {24'b0, flag_set}, 32'd0);
    endtask

    task automatic t_tick_in_window();
        pulse_tick();
        repeat (10) @(negedge clk);
        pulse_tick();
        chk("R4 uip still set", {31'b0, uip}, 32'd1);
        repeat (WIN - 1 - 12) @(negedge clk);
        chk("R4 uip before close", {31'b0, uip}, 32'd1);
        @(negedge clk);
        chk_time("R4 single advance", 8'h12, 8'h34, 8'h58);
        pulse_tick();
        finish_window("R4 next window");
        chk_time("R4 next second", 8'h12, 8'h34, 8'h59);
    endtask

    task automatic t_halt();
        @(negedge clk) chain_ctl = 2'b11;
        pulse_tick();
        chk("R2 no uip when halted", {31'b0, uip}, 32'd0);
        @(negedge clk);
        chk_time("R2 time held", 8'h12, 8'h34, 8'h59);
        @(negedge clk) chain_ctl = 2'b01;
        pulse_tick();
        finish_window("R2 resumed window");
        chk_time("R2 advanced once", 8'h12, 8'h35, 8'h00);
    endtask

    task automatic t_set();
        @(negedge clk) set_mode = 1'b1;
        for (int i = 0; i < 3; i++) begin
            pulse_tick();
            chk("R5 no uip in set", {31'b0, uip}, 32'd0);
            repeat (3) @(negedge clk);
        end
        chk_time("R5 frozen", 8'h12, 8'h35, 8'h00);
        @(negedge clk) set_mode = 1'b0;
        pulse_tick();
        finish_window("R5 window after set");
        chk_time("R5 all seconds counted", 8'h12, 8'h35, 8'h04);
    endtask

    task automatic t_update_flag();
        @(negedge clk) upd_ie = 1'b1;
        pulse_tick();
        finish_window("R6 window");
        chk("R6 update mask", {24'b0, flag_set}, 32'h90);
        @(negedge clk);
        chk("R6 mask one cycle", {24'b0, flag_set}, 32'h00);
        @(negedge clk) upd_ie = 1'b0;
    endtask

    task automatic t_alarm();
        @(negedge clk);
        alm_ie = 1'b1; alm_hour = 8'h01; alm_min = 8'h02; alm_sec = 8'h04;
        load(8'h01, 8'h02, 8'h03);
        pulse_tick();
        finish_window("R7 window");
        chk("R7 alarm match", {24'b0, flag_set}, 32'hA0);
        @(negedge clk);
        chk("R7 alarm one cycle", {24'b0, flag_set}, 32'h00);
        alm_sec = 8'h09;
        pulse_tick();
        finish_window("R7 window b");
        chk("R7 alarm mismatch", {24'b0, flag_set}, 32'h00);
        @(negedge clk);
        alm_hour = 8'hC0; alm_min = 8'hFF; alm_sec = 8'h06;
        upd_ie = 1'b1;
        pulse_tick();
        finish_window("R8 window");
        chk("R8 dont care fields", {24'b0, flag_set}, 32'hB0);
        @(negedge clk);
        alm_ie = 1'b0; upd_ie = 1'b0;
    endtask

    task automatic t_binary_wrap();
        @(negedge clk) bin_mode = 1'b1;
        @(negedge clk);
        chk_time("R13 to binary", 8'h01, 8'h02, 8'h06);
        load(8'h17, 8'h3B, 8'h3B);
        pulse_tick();
        chk("R11 carry pulse", {31'b0, day_carry}, 32'd1);
        @(negedge clk);
        chk("R11 carry one cycle", {31'b0, day_carry}, 32'd0);
        repeat (WIN - 2) @(negedge clk);
        @(negedge clk);
        chk_time("R11 midnight wrap", 8'h00, 8'h00, 8'h00);
        load(8'h00, 8'h00, 8'h2D);
        chk_time("R9 binary load", 8'h00, 8'h00, 8'h2D);
        @(negedge clk) bin_mode = 1'b0;
        @(negedge clk);
        chk_time("R13 back to bcd", 8'h00, 8'h00, 8'h45);
    endtask

    task automatic t_twelve_hour();
        load(8'h13, 8'h00, 8'h00);
        @(negedge clk) hr24 = 1'b0;
        @(negedge clk);
        chk("R10 13h as 1 PM", {24'b0, time_hour}, 32'h81);
        load(8'h91, 8'h59, 8'h59);
        pulse_tick();
        chk("R11 carry from 11 PM", {31'b0, day_carry}, 32'd1);
        finish_window("R10 window");
        chk_time("R10 midnight as 12 AM", 8'h12, 8'h00, 8'h00);
        load(8'h11, 8'h59, 8'h59);
        pulse_tick();
        chk("R11 no carry at noon", {31'b0, day_carry}, 32'd0);
        finish_window("R10 window b");
        chk_time("R10 noon as 12 PM", 8'h92, 8'h00, 8'h00);
        @(negedge clk) hr24 = 1'b1;
        @(negedge clk);
        chk("R13 back to 24h", {24'b0, time_hour}, 32'h12);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        @(negedge clk) rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_basic();
        t_tick_in_window();
        t_halt();
        t_set();
        t_update_flag();
        t_alarm();
        t_binary_wrap();
        t_twelve_hour();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule